// File: doc/BRIEF.md
# Auxiliary System Control Register Block

This block is a small memory-mapped bank of control registers for a workstation I/O controller. It sits on a simple synchronous register bus and holds a configuration byte, a diagnostic byte, a modem-control byte, a 16-bit LED pattern, two auxiliary bytes and a 32-bit system-control word. Writes to certain bits turn into hardware side effects: a one-cycle floppy terminal-count strobe, a CPU halt strobe, and sticky power-off and system-reset requests.

The block also watches a power-failing input. When that input changes while the configuration enables power interrupts, a power-fail status bit in the second auxiliary register records the new level. A level interrupt is high while that status bit and the enable are both set, and software clears the status with a write-one bit. A synchronous reset clears the configuration, auxiliary and modem-control state but leaves the diagnostic, LED and system-control contents alone. This lets software read back a reset-status flag after a commanded reset.

Top module: `sysaux_ctrl`

## Requirements
- R1: Register groups are selected by address bits 27:16 (mask 0x0fff0000): LED at 0x0160, configuration at 0x0180, diagnostic at 0x01a0, modem control at 0x01b0, system control at 0x01f0. The first auxiliary register, the second auxiliary register and the power-management register are matched on full addresses given by parameters (defaults 0x01900000, 0x01910000, 0x01920000). Unmapped addresses read zero.
- R2: The configuration, diagnostic and modem-control registers store wdata[7:0] and read back zero-extended. The LED register stores wdata[15:0].
- R3: On each change of pwr_fail_i, aux2 bit 5 becomes 1 if the new level is 1 and configuration bit 3 was set at the time of the change. Otherwise it becomes 0. Without a change, bit 5 holds its value.
- R4: pwr_irq_o is high exactly while aux2 bit 5 and configuration bit 3 are both 1.
- R5: A write to aux2 stores only wdata[1:0] in bits 1:0 and keeps bit 5. Bits 7:6 and 4:2 read as zero.
- R6: A write to aux2 with wdata[1] = 1 clears bit 5, and the interrupt falls with it.
- R7: A write to aux2 with wdata[0] = 1 raises pwr_off_req_o, which stays high until reset.
- R8: A write to aux1 stores wdata[7:0]. If wdata[0] = 1, fdc_tc_o is high for exactly the one cycle after the write edge.
- R9: Any write to the power-management address makes cpu_halt_o high for the one cycle after the write edge, whatever the data.
- R10: A write to system control with wdata[0] = 1 loads the register with 0x00000002 and raises sys_rst_req_o, which stays high until reset. Any other write stores wdata.
- R11: rst clears configuration, aux1, aux2, modem control and all request and strobe outputs. The diagnostic, LED and system-control registers keep their contents.
- R12: rdata_o is registered. It shows, one clock after the address is presented, the register contents as of that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | 32 | Bus address |
| we_i | input | 1 | Write enable |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| pwr_fail_i | input | 1 | Power-failing indication |
| pwr_irq_o | output | 1 | Level power-fail interrupt |
| fdc_tc_o | output | 1 | Floppy terminal-count strobe |
| cpu_halt_o | output | 1 | CPU halt strobe |
| pwr_off_req_o | output | 1 | Sticky power-off request |
| sys_rst_req_o | output | 1 | Sticky system reset request |

## Verification
On every cycle, the assertions check the following: the interrupt level against the status and enable bits, the always-zero bits of aux2, that each strobe traces back to a qualifying write one edge earlier, and that the power-off and reset requests stay high once raised. Only the bench's scenarios can show three things. The first is the capture rule for the power-fail status, including changes that occur while the enable is clear. The second is which registers survive a soft reset. The third is the exact read-back values after masking and after a commanded reset.

// File: rtl/sysaux_pkg.sv
package sysaux_pkg;
  typedef enum logic [3:0] {
    SEL_NONE, SEL_LED, SEL_CFG, SEL_DIAG, SEL_MDM,
    SEL_SYS, SEL_AUX1, SEL_AUX2, SEL_PM
  } sel_e;

  localparam int AUX2_OFF_BIT  = 0;
  localparam int AUX2_CLR_BIT  = 1;
  localparam int AUX2_FAIL_BIT = 5;
  localparam int CFG_EN_BIT    = 3;
endpackage

// File: rtl/sysaux_decode.sv
module sysaux_decode
  import sysaux_pkg::*;
#(
  parameter int          AW        = 32,
  parameter logic [31:0] GRP_MASK  = 32'h0fff_0000,
  parameter logic [31:0] LED_OFF   = 32'h0160_0000,
  parameter logic [31:0] CFG_OFF   = 32'h0180_0000,
  parameter logic [31:0] DIAG_OFF  = 32'h01a0_0000,
  parameter logic [31:0] MDM_OFF   = 32'h01b0_0000,
  parameter logic [31:0] SYS_OFF   = 32'h01f0_0000,
  parameter logic [31:0] AUX1_ADDR = 32'h0190_0000,
  parameter logic [31:0] AUX2_ADDR = 32'h0191_0000,
  parameter logic [31:0] PM_ADDR   = 32'h0192_0000
) (
  input  logic [AW-1:0] addr_i,
  output sel_e          sel_o
);
  logic [AW-1:0] grp;
  assign grp = addr_i & GRP_MASK[AW-1:0];

  always_comb begin
    sel_o = SEL_NONE;
    if      (addr_i == AUX1_ADDR[AW-1:0]) sel_o = SEL_AUX1;
    else if (addr_i == AUX2_ADDR[AW-1:0]) sel_o = SEL_AUX2;
    else if (addr_i == PM_ADDR[AW-1:0])   sel_o = SEL_PM;
    else if (grp == LED_OFF[AW-1:0])      sel_o = SEL_LED;
    else if (grp == CFG_OFF[AW-1:0])      sel_o = SEL_CFG;
    else if (grp == DIAG_OFF[AW-1:0])     sel_o = SEL_DIAG;
    else if (grp == MDM_OFF[AW-1:0])      sel_o = SEL_MDM;
    else if (grp == SYS_OFF[AW-1:0])      sel_o = SEL_SYS;
  end
endmodule

// File: rtl/sysaux_pwrfail.sv
module sysaux_pwrfail
  import sysaux_pkg::*;
#(
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pf_i,
  input  logic          en_q_i,
  input  logic          en_d_i,
  input  logic          wr_i,
  input  logic [1:0]    wbits_i,
  output logic [RW-1:0] aux2_o,
  output logic          irq_o
);
  logic pf_prev = 1'b0;
  logic fail_d;
  logic [RW-1:0] aux2_q, aux2_d;

  always_comb begin
    fail_d = aux2_q[AUX2_FAIL_BIT];
    if (pf_i != pf_prev) fail_d = pf_i & en_q_i;
    aux2_d = aux2_q;
    aux2_d[AUX2_FAIL_BIT] = fail_d;
    if (wr_i) begin
      aux2_d = '0;
      aux2_d[1:0] = wbits_i;
      aux2_d[AUX2_FAIL_BIT] = fail_d & ~wbits_i[AUX2_CLR_BIT];
    end
  end

  always_ff @(posedge clk) begin
    pf_prev <= pf_i;
    if (rst) begin
      aux2_q <= '0;
      irq_o  <= 1'b0;
    end else begin
      aux2_q <= aux2_d;
      irq_o  <= aux2_d[AUX2_FAIL_BIT] & en_d_i;
    end
  end

  assign aux2_o = aux2_q;

  assert_irq_level_R4: assert property (@(posedge clk) disable iff (rst)
    irq_o == (aux2_q[AUX2_FAIL_BIT] && en_q_i));

  assert_aux2_zero_bits_R5: assert property (@(posedge clk) disable iff (rst)
    aux2_q[RW-1:6] == '0 && aux2_q[4:2] == '0);
endmodule

// File: rtl/sysaux_ctrl.sv
module sysaux_ctrl
  import sysaux_pkg::*;
#(
  parameter int          AW        = 32,
  parameter int          DW        = 32,
  parameter int          BW        = 8,
  parameter int          LW        = 16,
  parameter logic [31:0] AUX1_ADDR = 32'h0190_0000,
  parameter logic [31:0] AUX2_ADDR = 32'h0191_0000,
  parameter logic [31:0] PM_ADDR   = 32'h0192_0000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          pwr_fail_i,
  output logic          pwr_irq_o,
  output logic          fdc_tc_o,
  output logic          cpu_halt_o,
  output logic          pwr_off_req_o,
  output logic          sys_rst_req_o
);
  localparam logic [DW-1:0] RST_STAT = DW'(2);

  sel_e sel;
  logic [BW-1:0] cfg_q, cfg_d, aux1_q, mdm_q, aux2;
  logic [BW-1:0] diag_q = '0;
  logic [LW-1:0] led_q  = '0;
  logic [DW-1:0] sys_q  = '0;
  logic [DW-1:0] rd_mux;
  logic wr_cfg, wr_aux1, wr_aux2, wr_pm, wr_sys;

  sysaux_decode #(.AW(AW), .AUX1_ADDR(AUX1_ADDR), .AUX2_ADDR(AUX2_ADDR),
                  .PM_ADDR(PM_ADDR)) dec_i (
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  assign wr_cfg  = we_i && sel == SEL_CFG;
  assign wr_aux1 = we_i && sel == SEL_AUX1;
  assign wr_aux2 = we_i && sel == SEL_AUX2;
  assign wr_pm   = we_i && sel == SEL_PM;
  assign wr_sys  = we_i && sel == SEL_SYS;
  assign cfg_d   = wr_cfg ? wdata_i[BW-1:0] : cfg_q;

  sysaux_pwrfail #(.RW(BW)) pf_i (
    .clk     (clk),
    .rst     (rst),
    .pf_i    (pwr_fail_i),
    .en_q_i  (cfg_q[CFG_EN_BIT]),
    .en_d_i  (cfg_d[CFG_EN_BIT]),
    .wr_i    (wr_aux2),
    .wbits_i (wdata_i[1:0]),
    .aux2_o  (aux2),
    .irq_o   (pwr_irq_o)
  );

  // Registers cleared by reset, plus strobes and sticky requests
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q         <= '0;
      aux1_q        <= '0;
      mdm_q         <= '0;
      fdc_tc_o      <= 1'b0;
      cpu_halt_o    <= 1'b0;
      pwr_off_req_o <= 1'b0;
      sys_rst_req_o <= 1'b0;
    end else begin
      cfg_q      <= cfg_d;
      fdc_tc_o   <= wr_aux1 && wdata_i[0];
      cpu_halt_o <= wr_pm;
      if (wr_aux1) aux1_q <= wdata_i[BW-1:0];
      if (we_i && sel == SEL_MDM) mdm_q <= wdata_i[BW-1:0];
      if (wr_aux2 && wdata_i[AUX2_OFF_BIT]) pwr_off_req_o <= 1'b1;
      if (wr_sys && wdata_i[0]) sys_rst_req_o <= 1'b1;
    end
  end

  // Registers that survive reset
  always_ff @(posedge clk) begin
    if (we_i && sel == SEL_DIAG) diag_q <= wdata_i[BW-1:0];
    if (we_i && sel == SEL_LED)  led_q  <= wdata_i[LW-1:0];
    if (wr_sys) sys_q <= wdata_i[0] ? RST_STAT : wdata_i;
  end

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_CFG:  rd_mux = DW'(cfg_q);
      SEL_DIAG: rd_mux = DW'(diag_q);
      SEL_MDM:  rd_mux = DW'(mdm_q);
      SEL_LED:  rd_mux = DW'(led_q);
      SEL_SYS:  rd_mux = sys_q;
      SEL_AUX1: rd_mux = DW'(aux1_q);
      SEL_AUX2: rd_mux = DW'(aux2);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else     rdata_o <= rd_mux;
  end

  assert_tc_cause_R8: assert property (@(posedge clk) disable iff (rst)
    fdc_tc_o |-> $past(wr_aux1 && wdata_i[0]));

  assert_halt_cause_R9: assert property (@(posedge clk) disable iff (rst)
    cpu_halt_o |-> $past(wr_pm));

  assert_pwroff_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    pwr_off_req_o |=> pwr_off_req_o);

  assert_sysrst_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    sys_rst_req_o |=> sys_rst_req_o);
endmodule

// File: tb/sysaux_ctrl_tb.sv
module sysaux_ctrl_tb_top;
  localparam logic [31:0] A_LED  = 32'h0160_0000;
  localparam logic [31:0] A_CFG  = 32'h0180_0000;
  localparam logic [31:0] A_DIAG = 32'h01a0_0000;
  localparam logic [31:0] A_MDM  = 32'h01b0_0000;
  localparam logic [31:0] A_SYS  = 32'h01f0_0000;
  localparam logic [31:0] A_AUX1 = 32'h0190_0000;
  localparam logic [31:0] A_AUX2 = 32'h0191_0000;
  localparam logic [31:0] A_PM   = 32'h0192_0000;

  logic clk = 0, rst = 1, we = 0, pf = 0;
  logic [31:0] addr = 0, wdata = 0, rdata;
  logic irq, tc, halt, poff, srst;
  int errors = 0, checks = 0, cycles = 0;

  always #10 clk = ~clk;

  sysaux_ctrl dut_i (
    .clk(clk), .rst(rst), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .pwr_fail_i(pf), .pwr_irq_o(irq), .fdc_tc_o(tc),
    .cpu_halt_o(halt), .pwr_off_req_o(poff), .sys_rst_req_o(srst)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1;
    @(posedge clk); @(negedge clk);
    we = 0; addr = 32'h0;
  endtask

  task automatic rd(input logic [31:0] a, output logic [31:0] d);
    addr = a;
    @(posedge clk); @(negedge clk);
    d = rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset_state();
    logic [31:0] v;
    chk("R11 irq after reset", {31'b0, irq}, 0);
    chk("R11 requests after reset", {28'b0, tc, halt, poff, srst}, 0);
    rd(A_CFG, v);  chk("R11 cfg reset", v, 0);
    rd(A_AUX2, v); chk("R11 aux2 reset", v, 0);
    rd(32'h0abc_0000, v); chk("R1 unmapped reads zero", v, 0);
  endtask

  task automatic t_byte_regs();
    logic [31:0] v;
    wr(A_CFG, 32'hABCD_1234);  rd(A_CFG, v);  chk("R2 cfg low byte", v, 32'h34);
    wr(A_DIAG, 32'h0000_FF77); rd(A_DIAG, v); chk("R2 diag low byte", v, 32'h77);
    wr(A_MDM, 32'h1234_5699);  rd(A_MDM, v);  chk("R2 mdm low byte", v, 32'h99);
    wr(A_LED, 32'hDEAD_BEEF);  rd(A_LED, v);  chk("R2 led 16 bits", v, 32'hBEEF);
    // bits outside the mask ignored by group decode
    rd(32'hF180_0000, v); chk("R1 group decode masks top bits", v, 32'h34);
    wr(A_CFG, 32'h0);
  endtask

  task automatic t_pwrfail();
    logic [31:0] v;
    wr(A_CFG, 32'h08);
    pf = 1; @(negedge clk);
    chk("R3 irq after enabled fail", {31'b0, irq}, 1);
    rd(A_AUX2, v); chk("R3 aux2 fail bit set", v, 32'h20);
    wr(A_AUX2, 32'hFC);
    rd(A_AUX2, v); chk("R5 aux2 keeps bit5, masks others", v, 32'h20);
    chk("R4 irq still high", {31'b0, irq}, 1);
    wr(A_CFG, 32'h00);
    chk("R4 irq drops with enable", {31'b0, irq}, 0);
    wr(A_CFG, 32'h08);
    chk("R4 irq back with enable", {31'b0, irq}, 1);
    wr(A_AUX2, 32'h02);
    chk("R6 irq cleared by write-one", {31'b0, irq}, 0);
    rd(A_AUX2, v); chk("R6 aux2 after clear", v, 32'h02);
    idle(2);
    chk("R3 no re-set without change", {31'b0, irq}, 0);
    pf = 0; @(negedge clk);
    wr(A_CFG, 32'h00);
    pf = 1; @(negedge clk);
    rd(A_AUX2, v); chk("R3 change while disabled ignored", v, 32'h02);
    wr(A_CFG, 32'h08);
    chk("R3 later enable does not capture", {31'b0, irq}, 0);
    pf = 0; @(negedge clk); pf = 1; @(negedge clk);
    chk("R3 captured on next change", {31'b0, irq}, 1);
    pf = 0; @(negedge clk);
    chk("R3 deassert clears", {31'b0, irq}, 0);
    rd(A_AUX2, v); chk("R3 aux2 bit5 cleared", v, 32'h02);
  endtask

  task automatic t_aux1();
    logic [31:0] v;
    wr(A_AUX1, 32'h0000_0181);
    chk("R8 tc pulse high", {31'b0, tc}, 1);
    @(negedge clk);
    chk("R8 tc pulse one cycle", {31'b0, tc}, 0);
    rd(A_AUX1, v); chk("R8 aux1 low byte", v, 32'h81);
    wr(A_AUX1, 32'h80);
    chk("R8 no pulse bit0 clear", {31'b0, tc}, 0);
  endtask

  task automatic t_halt();
    wr(A_PM, 32'h0);
    chk("R9 halt pulse", {31'b0, halt}, 1);
    @(negedge clk);
    chk("R9 halt one cycle", {31'b0, halt}, 0);
  endtask

  task automatic t_poweroff();
    wr(A_AUX2, 32'h00);
    chk("R7 no poweroff bit0 clear", {31'b0, poff}, 0);
    wr(A_AUX2, 32'h01);
    chk("R7 poweroff raised", {31'b0, poff}, 1);
    wr(A_AUX2, 32'h00); idle(3);
    chk("R7 poweroff sticky", {31'b0, poff}, 1);
  endtask

  task automatic t_sysctl();
    logic [31:0] v;
    wr(A_SYS, 32'h1234_565A);
    rd(A_SYS, v); chk("R10 sysctl stores data", v, 32'h1234_565A);
    chk("R10 no reset req", {31'b0, srst}, 0);
    wr(A_SYS, 32'hFFFF_FFFF);
    chk("R10 reset req raised", {31'b0, srst}, 1);
    rd(A_SYS, v); chk("R10 reset status value", v, 32'h2);
  endtask

  task automatic t_soft_reset();
    logic [31:0] v;
    wr(A_CFG, 32'h08); wr(A_MDM, 32'h55); wr(A_AUX1, 32'h66);
    rst = 1; idle(2); rst = 0; @(negedge clk);
    chk("R11 requests cleared", {30'b0, poff, srst}, 0);
    rd(A_DIAG, v); chk("R11 diag kept", v, 32'h77);
    rd(A_SYS, v);  chk("R11 sysctl kept", v, 32'h2);
    rd(A_LED, v);  chk("R11 led kept", v, 32'hBEEF);
    rd(A_CFG, v);  chk("R11 cfg cleared", v, 0);
    rd(A_MDM, v);  chk("R11 mdm cleared", v, 0);
    rd(A_AUX1, v); chk("R11 aux1 cleared", v, 0);
  endtask

  task automatic t_read_latency();
    addr = A_DIAG;
    @(posedge clk); #1;
    chk("R12 rdata valid after one edge", rdata, 32'h77);
    addr = A_AUX2;
    #2;
    chk("R12 rdata registered", rdata, 32'h77);
    @(negedge clk);
  endtask

  initial begin
    idle(3); rst = 0; @(negedge clk);
    t_reset_state();
    t_byte_regs();
    t_pwrfail();
    t_aux1();
    t_halt();
    t_poweroff();
    t_sysctl();
    t_soft_reset();
    t_read_latency();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule